// File: doc/BRIEF.md
# Adaptive Replication Level Controller

This block decides how often shared read-only L2 blocks are copied into a core's local L2 slice. It keeps one replication level between 0 and 7. From four kinds of event pulses it estimates whether the level one step up or one step down would pay off. A step up gains hit cycles and loses miss cycles. A step down gains miss cycles and loses hit cycles. It moves the level only when several evaluation intervals in a row agree on the direction of the move.

When L1 evicts a shared read-only block, the cache presents an eviction request on a valid/ready stream. Each accepted request produces one registered decision on an output valid/ready stream. The decision is a probabilistic one: a 16-bit pseudo-random value is compared against a probability threshold taken from the current level. The decision bit is the replica marker that the cache writes into the 1-bit replica flag of the L2 block.

Back-pressure rules: the eviction stream is accepted only when the decision register is empty or is being drained in the same cycle. A pending decision stays stable until the consumer asserts ready.

Top module: `repl_level_ctrl`

## Requirements
- R1: After reset, `level_o` equals INIT_LVL (default 3), `rep_valid_o` is 0 and `evict_ready_o` is 1.
- R2: Every cycle, each of the four pulse inputs that is high adds one event. An evaluation interval closes in the cycle its event total reaches MIN_EVENTS. All interval counts then restart from zero.
- R3: When an interval closes, up_net = hit_gain_up − miss_loss_up and dn_net = miss_gain_dn − hit_loss_dn, counted over that interval. The prediction is UP if up_net > 0 and up_net ≥ dn_net. Otherwise it is DOWN if dn_net > 0. Otherwise it is HOLD.
- R4: The level moves one step in the predicted direction at the fourth consecutive closing interval with the same non-HOLD prediction. The agreement run then restarts, so another four agreeing intervals are needed for the next step. `level_o` changes one cycle after the closing cycle.
- R5: An interval whose prediction differs from the previous one starts a new run of length one. A HOLD interval clears the run.
- R6: The level saturates: UP at 7 and DOWN at 0 leave it unchanged.
- R7: For level L, the threshold is T = floor((16·L + 3) / 7), which gives 0,2,5,7,9,11,14,16. The decision is 1 exactly when the low 4 bits of the LFSR state are less than T.
- R8: The LFSR is 16 bits wide and seeded at reset to 0xACE1. Its next state is {state[14:0], state[15]^state[13]^state[12]^state[10]}. It advances once per accepted eviction, and only then. The decision uses the state held before the advance.
- R9: An eviction is accepted when `evict_valid_i && evict_ready_o`, where `evict_ready_o = !rep_valid_o || rep_ready_i`. The decision appears on `rep_valid_o`/`rep_flag_o` in the next cycle. It stays unchanged while `rep_ready_i` is low.
- R10: At level 0 every decision is 0. At level 7 every decision is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_gain_up_i | input | 1 | Pulse: hit cycle a higher level would save |
| miss_loss_up_i | input | 1 | Pulse: miss cycle a higher level would add |
| miss_gain_dn_i | input | 1 | Pulse: miss cycle a lower level would save |
| hit_loss_dn_i | input | 1 | Pulse: hit cycle a lower level would lose |
| evict_valid_i | input | 1 | Eviction request of a shared read-only block |
| evict_ready_o | output | 1 | Eviction request can be accepted |
| rep_valid_o | output | 1 | Decision available |
| rep_ready_i | input | 1 | Consumer takes the decision |
| rep_flag_o | output | 1 | Replicate decision / replica marker |
| level_o | output | 3 | Current replication level |

## Verification
Assertions check several properties on every cycle:
- the interval event counter stays below its closing value;
- the agreement run stays shorter than four;
- the level moves by at most one step per cycle and stays in range;
- a stalled decision holds its value;
- levels 0 and 7 force the decision.

Other properties only the bench scenarios can show:
- the exact prediction rule, including ties and HOLD;
- the reset of the agreement run after a disagreement;
- saturation at both ends;
- the bit-exact decision sequence derived from the LFSR at an intermediate level, including a request that waits under back-pressure and must not advance the LFSR.

// File: rtl/rlc_pkg.sv
package rlc_pkg;

  typedef enum logic [1:0] {
    PRED_HOLD = 2'd0,
    PRED_UP   = 2'd1,
    PRED_DOWN = 2'd2
  } pred_e;

  // Roughly linear map of a level onto a probability threshold out of 2**pw.
  function automatic int unsigned lvl_thresh(input int unsigned lvl,
                                             input int unsigned nlvl,
                                             input int unsigned pw);
    return (lvl * (32'd1 << pw) + (nlvl - 1) / 2) / (nlvl - 1);
  endfunction

endpackage

// File: rtl/rlc_interval.sv
module rlc_interval #(
  parameter int unsigned CNT_W      = 12,
  parameter int unsigned MIN_EVENTS = 1024
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hg_i,
  input  logic          hl_i,
  input  logic          lg_i,
  input  logic          ll_i,
  output logic          eval_o,
  output rlc_pkg::pred_e pred_o
);
  localparam int unsigned CW = CNT_W + 1;

  logic [CW-1:0] hg_c, hl_c, lg_c, ll_c, ev_c;
  logic [CW-1:0] hg_n, hl_n, lg_n, ll_n, ev_n;
  logic signed [CW:0] up_net, dn_net;
  logic close;
  rlc_pkg::pred_e pred_d;

  always_comb begin
    hg_n   = hg_c + CW'(hg_i);
    hl_n   = hl_c + CW'(hl_i);
    lg_n   = lg_c + CW'(lg_i);
    ll_n   = ll_c + CW'(ll_i);
    ev_n   = ev_c + CW'(hg_i) + CW'(hl_i) + CW'(lg_i) + CW'(ll_i);
    close  = (ev_n >= CW'(MIN_EVENTS));
    up_net = $signed({1'b0, hg_n}) - $signed({1'b0, hl_n});
    dn_net = $signed({1'b0, lg_n}) - $signed({1'b0, ll_n});
    if (up_net > 0 && up_net >= dn_net)
      pred_d = rlc_pkg::PRED_UP;
    else if (dn_net > 0)
      pred_d = rlc_pkg::PRED_DOWN;
    else
      pred_d = rlc_pkg::PRED_HOLD;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hg_c   <= '0;
      hl_c   <= '0;
      lg_c   <= '0;
      ll_c   <= '0;
      ev_c   <= '0;
      eval_o <= 1'b0;
      pred_o <= rlc_pkg::PRED_HOLD;
    end else if (close) begin
      hg_c   <= '0;
      hl_c   <= '0;
      lg_c   <= '0;
      ll_c   <= '0;
      ev_c   <= '0;
      eval_o <= 1'b1;
      pred_o <= pred_d;
    end else begin
      hg_c   <= hg_n;
      hl_c   <= hl_n;
      lg_c   <= lg_n;
      ll_c   <= ll_n;
      ev_c   <= ev_n;
      eval_o <= 1'b0;
    end
  end

  // R2
  ev_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_c < CW'(MIN_EVENTS));

endmodule

// File: rtl/rlc_vote.sv
module rlc_vote #(
  parameter int unsigned NUM_LVL  = 8,
  parameter int unsigned INIT_LVL = 3,
  parameter int unsigned AGREE    = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       eval_i,
  input  rlc_pkg::pred_e             pred_i,
  output logic [$clog2(NUM_LVL)-1:0] level_o
);
  localparam int unsigned LW = $clog2(NUM_LVL);
  localparam int unsigned AW = $clog2(AGREE + 1);
  localparam logic [LW-1:0] TOP_LVL = LW'(NUM_LVL - 1);

  logic [AW-1:0] run_q;
  rlc_pkg::pred_e last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= '0;
      last_q  <= rlc_pkg::PRED_HOLD;
      level_o <= LW'(INIT_LVL);
    end else if (eval_i) begin
      last_q <= pred_i;
      if (pred_i == rlc_pkg::PRED_HOLD) begin
        run_q <= '0;
      end else if (pred_i == last_q && run_q != '0) begin
        if (run_q == AW'(AGREE - 1)) begin
          run_q <= '0;
          if (pred_i == rlc_pkg::PRED_UP && level_o != TOP_LVL)
            level_o <= level_o + 1'b1;
          else if (pred_i == rlc_pkg::PRED_DOWN && level_o != '0)
            level_o <= level_o - 1'b1;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end else begin
        run_q <= AW'(1);
      end
    end
  end

  // R5
  run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q < AW'(AGREE));

  // R4
  one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level_o != $past(level_o)) |->
      (level_o == $past(level_o) + 1'b1 || level_o == $past(level_o) - 1'b1));

  // R6
  lvl_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level_o <= TOP_LVL);

endmodule

// File: rtl/rlc_filter.sv
module rlc_filter #(
  parameter int unsigned NUM_LVL = 8,
  parameter int unsigned LFSR_W  = 16,
  parameter int unsigned PROB_W  = 4,
  parameter logic [LFSR_W-1:0] TAPS = 16'hB400,
  parameter logic [LFSR_W-1:0] SEED = 16'hACE1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [$clog2(NUM_LVL)-1:0] level_i,
  input  logic                       evict_valid_i,
  output logic                       evict_ready_o,
  output logic                       rep_valid_o,
  input  logic                       rep_ready_i,
  output logic                       rep_flag_o
);
  localparam int unsigned LW = $clog2(NUM_LVL);
  localparam logic [LW-1:0] TOP_LVL = LW'(NUM_LVL - 1);

  logic [LFSR_W-1:0] lfsr_q;
  logic [PROB_W:0]   thr;
  logic              fb, take, decide;

  always_comb begin
    thr    = (PROB_W+1)'(rlc_pkg::lvl_thresh(32'(level_i), NUM_LVL, PROB_W));
    fb     = ^(lfsr_q & TAPS);
    decide = ({1'b0, lfsr_q[PROB_W-1:0]} < thr);
  end

  assign evict_ready_o = !rep_valid_o || rep_ready_i;
  assign take          = evict_valid_i && evict_ready_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfsr_q      <= SEED;
      rep_valid_o <= 1'b0;
      rep_flag_o  <= 1'b0;
    end else if (take) begin
      lfsr_q      <= {lfsr_q[LFSR_W-2:0], fb};
      rep_valid_o <= 1'b1;
      rep_flag_o  <= decide;
    end else if (rep_ready_i) begin
      rep_valid_o <= 1'b0;
    end
  end

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rep_valid_o && !rep_ready_i) |=> (rep_valid_o && $stable(rep_flag_o)));

  // R10
  lvl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && level_i == '0) |=> !rep_flag_o);

  // R10
  lvl_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && level_i == TOP_LVL) |=> rep_flag_o);

  // R8
  lfsr_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0);

endmodule

// File: rtl/repl_level_ctrl.sv
module repl_level_ctrl #(
  parameter int unsigned NUM_LVL    = 8,
  parameter int unsigned INIT_LVL   = 3,
  parameter int unsigned AGREE      = 4,
  parameter int unsigned CNT_W      = 12,
  parameter int unsigned MIN_EVENTS = 1024,
  parameter int unsigned LFSR_W     = 16,
  parameter int unsigned PROB_W     = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hit_gain_up_i,
  input  logic       miss_loss_up_i,
  input  logic       miss_gain_dn_i,
  input  logic       hit_loss_dn_i,
  input  logic       evict_valid_i,
  output logic       evict_ready_o,
  output logic       rep_valid_o,
  input  logic       rep_ready_i,
  output logic       rep_flag_o,
  output logic [2:0] level_o
);
  localparam int unsigned LW = $clog2(NUM_LVL);

  logic           eval;
  rlc_pkg::pred_e pred;
  logic [LW-1:0]  level;

  rlc_interval #(.CNT_W(CNT_W), .MIN_EVENTS(MIN_EVENTS)) u_interval (
    .clk(clk), .rst_n(rst_n),
    .hg_i(hit_gain_up_i), .hl_i(miss_loss_up_i),
    .lg_i(miss_gain_dn_i), .ll_i(hit_loss_dn_i),
    .eval_o(eval), .pred_o(pred)
  );

  rlc_vote #(.NUM_LVL(NUM_LVL), .INIT_LVL(INIT_LVL), .AGREE(AGREE)) u_vote (
    .clk(clk), .rst_n(rst_n), .eval_i(eval), .pred_i(pred), .level_o(level)
  );

  rlc_filter #(.NUM_LVL(NUM_LVL), .LFSR_W(LFSR_W), .PROB_W(PROB_W)) u_filter (
    .clk(clk), .rst_n(rst_n), .level_i(level),
    .evict_valid_i(evict_valid_i), .evict_ready_o(evict_ready_o),
    .rep_valid_o(rep_valid_o), .rep_ready_i(rep_ready_i),
    .rep_flag_o(rep_flag_o)
  );

  assign level_o = 3'(level);

  // R4
  lvl_needs_eval_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level_o != $past(level_o)) |-> $past(eval));

endmodule

// File: tb/repl_level_ctrl_tb_top.sv
module repl_level_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MIN_EV = 8;

  logic clk = 0, rst_n = 0;
  logic hg = 0, hl = 0, lg = 0, ll = 0;
  logic ev_valid = 0, ev_ready, rp_valid, rp_ready = 0, rp_flag;
  logic [2:0] level;

  int total = 0, bad = 0;
  logic [15:0] lf = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  repl_level_ctrl #(.MIN_EVENTS(MIN_EV)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .hit_gain_up_i(hg), .miss_loss_up_i(hl), .miss_gain_dn_i(lg), .hit_loss_dn_i(ll),
    .evict_valid_i(ev_valid), .evict_ready_o(ev_ready),
    .rep_valid_o(rp_valid), .rep_ready_i(rp_ready), .rep_flag_o(rp_flag),
    .level_o(level)
  );

  // columns: hit_gain_up, miss_loss_up, miss_gain_dn, hit_loss_dn, expected level
  localparam int TBL [14][5] = '{
    '{6,2,0,0,3}, '{6,2,0,0,3}, '{6,2,0,0,3}, '{6,2,0,0,4},
    '{0,0,6,2,4}, '{6,2,0,0,4}, '{6,2,0,0,4}, '{4,0,4,0,4},
    '{6,2,0,0,5}, '{2,6,0,0,5}, '{0,0,6,2,5}, '{0,0,6,2,5},
    '{0,0,6,2,5}, '{1,0,5,2,4}
  };

  function automatic int thr_of(int l);
    return (16*l + 3) / 7;
  endfunction

  function automatic logic [15:0] lf_step(logic [15:0] s);
    return {s[14:0], s[15]^s[13]^s[12]^s[10]};
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulses(int a, int b, int c, int d);
    for (int i = 0; i < a; i++) begin @(negedge clk); {hg,hl,lg,ll} = 4'b1000; end
    for (int i = 0; i < b; i++) begin @(negedge clk); {hg,hl,lg,ll} = 4'b0100; end
    for (int i = 0; i < c; i++) begin @(negedge clk); {hg,hl,lg,ll} = 4'b0010; end
    for (int i = 0; i < d; i++) begin @(negedge clk); {hg,hl,lg,ll} = 4'b0001; end
    @(negedge clk); {hg,hl,lg,ll} = 4'b0000;
    repeat (3) @(negedge clk);
  endtask

  task automatic evict_once(string req);
    logic exp;
    @(negedge clk); ev_valid = 1; rp_ready = 1;
    exp = (int'(lf[3:0]) < thr_of(int'(level)));
    @(negedge clk); ev_valid = 0;
    lf = lf_step(lf);
    check({req, " valid"}, int'(rp_valid), 1);
    check({req, " flag"}, int'(rp_flag), int'(exp));
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic e1, e2;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    check("R1 level", int'(level), 3);
    check("R1 rep_valid", int'(rp_valid), 0);
    check("R1 evict_ready", int'(ev_ready), 1);

    // R7 R8: decisions at level 3
    for (int i = 0; i < 16; i++) evict_once("R7 R8 lvl3");

    // R9: back-pressure, waiting request must not advance LFSR
    @(negedge clk); ev_valid = 1; rp_ready = 0;
    e1 = (int'(lf[3:0]) < 7); lf = lf_step(lf);
    @(negedge clk);
    check("R9 valid", int'(rp_valid), 1);
    check("R9 flag", int'(rp_flag), int'(e1));
    check("R9 ready low", int'(ev_ready), 0);
    repeat (3) @(negedge clk);
    check("R9 held flag", int'(rp_flag), int'(e1));
    check("R9 held valid", int'(rp_valid), 1);
    e2 = (int'(lf[3:0]) < 7); lf = lf_step(lf);
    rp_ready = 1;
    @(negedge clk); ev_valid = 0;
    check("R9 second flag", int'(rp_flag), int'(e2));
    @(negedge clk);
    check("R9 drained", int'(rp_valid), 0);
    evict_once("R8 after stall");

    // R2 R3 R4 R5: table walk
    for (int r = 0; r < 14; r++) begin
      pulses(TBL[r][0], TBL[r][1], TBL[r][2], TBL[r][3]);
      check($sformatf("R2 R3 R4 R5 row%0d", r), int'(level), TBL[r][4]);
    end

    // R6: saturate high
    for (int i = 0; i < 16; i++) pulses(7, 1, 0, 0);
    check("R6 top", int'(level), 7);
    for (int i = 0; i < 6; i++) evict_once("R10 lvl7");

    // R6: saturate low
    for (int i = 0; i < 32; i++) pulses(0, 0, 7, 1);
    check("R6 bottom", int'(level), 0);
    for (int i = 0; i < 6; i++) evict_once("R10 lvl0");

    // R5: HOLD clears run, so 3 DOWN + HOLD + 3 DOWN from level 4 does not move
    for (int i = 0; i < 16; i++) pulses(7, 1, 0, 0);
    check("R4 back to 4", int'(level), 4);
    for (int i = 0; i < 3; i++) pulses(0, 0, 7, 1);
    pulses(0, 4, 0, 4);
    for (int i = 0; i < 3; i++) pulses(0, 0, 7, 1);
    check("R5 hold clears run", int'(level), 4);
    pulses(0, 0, 7, 1);
    check("R4 fourth down", int'(level), 3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule